// File: doc/BRIEF.md
# Compact Register Jump with Stack-Pointer Adjust

This block decodes and executes a single 16-bit compressed instruction. In one step it redirects fetch to the address held in the return-address register (register 31) and raises the stack pointer (register 29) by a small scaled constant. The instruction word, a valid strobe and the two 64-bit register values are captured in an input stage. All results are then formed combinationally from that stage, so they appear one clock after the inputs.

The fetch unit receives the new PC, the redirect strobe, the next instruction-set mode bit and a pending address-error flag for the target fetch. The register file receives a write enable and the 64-bit value for register 29. The jump has no delay slot, so a flush strobe discards the instruction that follows it in sequence. The parameter `WIDE_ISA` chooses between two cores. One also runs 32-bit instructions. The other runs only compressed code. The choice changes how bit 0 of the target is read and when an address error is predicted.

Top module: `cjump_stack_adj`

## Requirements
- R1: The word matches only when bits [15:10] equal 6'b010001 and bits [4:0] equal 5'b10011; bits [9:5] are an unsigned immediate and may take any value.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge (one-cycle latency); a new input has no effect on the outputs before that edge.
- R3: The stack increment is the 5-bit immediate shifted left by two and zero-extended (0 to 124 in steps of 4).
- R4: `sp_wdata_o` is the 32-bit sum of the increment and bits [31:0] of `sp_i`, sign-extended from bit 31 to 64 bits.
- R5: The stack sum wraps silently in 32 bits; for example, 0x7FFFFFFC plus 4 yields 0xFFFFFFFF80000000, and no error output reacts to the wrap.
- R6: `pc_o` equals `ra_i` with bit 0 forced to zero.
- R7: With `WIDE_ISA`=1, `isa_mode_o` equals bit 0 of `ra_i` (1 = compressed, 0 = 32-bit). `addr_err_o` is high exactly when `ra_i` bit 0 is 0 and bit 1 is 1.
- R8: With `WIDE_ISA`=0, `isa_mode_o` is 1. `addr_err_o` is high exactly when `ra_i` bit 0 is 0.
- R9: `redirect_o`, `sp_we_o` and `flush_o` are high together, and only when the captured word was valid and matched.
- R10: `sp_unpred_o` is high when bits [63:31] of `sp_i` are not all equal; `sp_wdata_o` is still the R4 result.
- R11: When the captured word is invalid or does not match, every output is zero.
- R12: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 16 | Compressed instruction word |
| ra_i | input | XLEN | Contents of register 31 |
| sp_i | input | XLEN | Contents of register 29 |
| match_o | output | 1 | Captured word is valid and decodes as this instruction |
| redirect_o | output | 1 | Fetch redirect strobe |
| pc_o | output | XLEN | New PC |
| isa_mode_o | output | 1 | Next instruction-set mode (1 = compressed) |
| sp_we_o | output | 1 | Register 29 write enable |
| sp_wdata_o | output | XLEN | Register 29 write-back value |
| flush_o | output | 1 | Discard the next sequential instruction |
| addr_err_o | output | 1 | Address error pending on the target fetch |
| sp_unpred_o | output | 1 | Register 29 held a value that was not a sign-extended word |

## Verification
The assertions check on every cycle that a matching input is answered one edge later. They also check the PC clearing, the low-word stack sum, the sign extension, the mode bit and the unpredictable flag. The three strobes must move together, and an address error may only appear with a redirect. The bench scenarios cover the rest. These are the exact corner values (zero and maximum immediate, the 32-bit wrap, a misaligned 32-bit-mode target) and the contrast between the two `WIDE_ISA` builds on the same target address. They also cover the quiet outputs during reset and the unchanged outputs before the capturing edge.

// File: rtl/cjsa_pkg.sv
package cjsa_pkg;
  localparam int unsigned INSTR_W   = 16;
  localparam int unsigned XLEN_DEF  = 64;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned IMM_W     = 5;
  localparam int unsigned IMM_LSB   = 5;
  localparam int unsigned IMM_SHIFT = 2;
  localparam int unsigned MAJ_W     = 6;
  localparam int unsigned MIN_W     = 5;
  localparam logic [MAJ_W-1:0] OPC_MAJOR = 6'b010001;
  localparam logic [MIN_W-1:0] OPC_MINOR = 5'b10011;

  typedef struct packed {
    logic             hit;
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/cjsa_decode.sv
module cjsa_decode
  import cjsa_pkg::*;
(
  input  logic               valid,
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  localparam int unsigned MAJ_LSB = INSTR_W - MAJ_W;

  logic major_ok;
  logic minor_ok;

  always_comb begin
    major_ok = (instr[INSTR_W-1:MAJ_LSB] == OPC_MAJOR);
    minor_ok = (instr[MIN_W-1:0] == OPC_MINOR);
    dec.hit  = valid && major_ok && minor_ok;
    dec.imm  = instr[IMM_LSB +: IMM_W];
  end
endmodule

// File: rtl/cjsa_sp_add.sv
module cjsa_sp_add
  import cjsa_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_DEF
) (
  input  logic [XLEN-1:0]  sp,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  sum_sext,
  output logic             unpred
);
  localparam int unsigned PAD_W = WORD_W - IMM_W - IMM_SHIFT;
  localparam int unsigned EXT_W = XLEN - WORD_W;
  localparam int unsigned TOP_W = XLEN - WORD_W + 1;

  logic [WORD_W-1:0] inc;
  logic [WORD_W-1:0] sum;
  logic [TOP_W-1:0]  upper;

  always_comb begin
    inc      = {{PAD_W{1'b0}}, imm, {IMM_SHIFT{1'b0}}};
    sum      = sp[WORD_W-1:0] + inc;
    sum_sext = {{EXT_W{sum[WORD_W-1]}}, sum};
    upper    = sp[XLEN-1:WORD_W-1];
    unpred   = !((&upper) || (~|upper));
  end
endmodule

// File: rtl/cjsa_target.sv
module cjsa_target #(
  parameter int unsigned XLEN     = 64,
  parameter bit          WIDE_ISA = 1'b1
) (
  input  logic [XLEN-1:0] ra,
  output logic [XLEN-1:0] pc,
  output logic            isa_mode,
  output logic            addr_err
);
  always_comb pc = {ra[XLEN-1:1], 1'b0};

  generate
    if (WIDE_ISA) begin : g_wide
      always_comb begin
        isa_mode = ra[0];
        addr_err = !ra[0] && ra[1];
      end
    end else begin : g_narrow
      always_comb begin
        isa_mode = 1'b1;
        addr_err = !ra[0];
      end
    end
  endgenerate
endmodule

// File: rtl/cjump_stack_adj.sv
module cjump_stack_adj
  import cjsa_pkg::*;
#(
  parameter int unsigned XLEN     = XLEN_DEF,
  parameter bit          WIDE_ISA = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [XLEN-1:0]    ra_i,
  input  logic [XLEN-1:0]    sp_i,
  output logic               match_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    pc_o,
  output logic               isa_mode_o,
  output logic               sp_we_o,
  output logic [XLEN-1:0]    sp_wdata_o,
  output logic               flush_o,
  output logic               addr_err_o,
  output logic               sp_unpred_o
);
  logic               vld_q, vld_d;
  logic [INSTR_W-1:0] instr_q, instr_d;
  logic [XLEN-1:0]    ra_q, ra_d;
  logic [XLEN-1:0]    sp_q, sp_d;
  logic               load_en;

  dec_t            dec;
  logic [XLEN-1:0] tgt_pc;
  logic            tgt_isa;
  logic            tgt_err;
  logic [XLEN-1:0] sp_new;
  logic            sp_odd;

  // next-state: the data stage loads only when a word is offered
  always_comb begin
    load_en = valid_i;
    vld_d   = valid_i;
    instr_d = load_en ? instr_i : instr_q;
    ra_d    = load_en ? ra_i    : ra_q;
    sp_d    = load_en ? sp_i    : sp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      instr_q <= '0;
      ra_q    <= '0;
      sp_q    <= '0;
    end else begin
      vld_q   <= vld_d;
      instr_q <= instr_d;
      ra_q    <= ra_d;
      sp_q    <= sp_d;
    end
  end

  cjsa_decode u_dec (
    .valid (vld_q),
    .instr (instr_q),
    .dec   (dec)
  );

  cjsa_target #(.XLEN(XLEN), .WIDE_ISA(WIDE_ISA)) u_tgt (
    .ra       (ra_q),
    .pc       (tgt_pc),
    .isa_mode (tgt_isa),
    .addr_err (tgt_err)
  );

  cjsa_sp_add #(.XLEN(XLEN)) u_add (
    .sp       (sp_q),
    .imm      (dec.imm),
    .sum_sext (sp_new),
    .unpred   (sp_odd)
  );

  // every result is gated by the decode hit; a miss leaves all outputs quiet
  always_comb begin
    match_o     = dec.hit;
    redirect_o  = dec.hit;
    sp_we_o     = dec.hit;
    flush_o     = dec.hit;
    pc_o        = dec.hit ? tgt_pc : '0;
    isa_mode_o  = dec.hit && tgt_isa;
    addr_err_o  = dec.hit && tgt_err;
    sp_wdata_o  = dec.hit ? sp_new : '0;
    sp_unpred_o = dec.hit && sp_odd;
  end
endmodule

// File: rtl/cjsa_checker.sv
module cjsa_checker
  import cjsa_pkg::*;
#(
  parameter int unsigned XLEN     = XLEN_DEF,
  parameter bit          WIDE_ISA = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               valid_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic [XLEN-1:0]    ra_i,
  input logic [XLEN-1:0]    sp_i,
  input logic               match_o,
  input logic               redirect_o,
  input logic [XLEN-1:0]    pc_o,
  input logic               isa_mode_o,
  input logic               sp_we_o,
  input logic [XLEN-1:0]    sp_wdata_o,
  input logic               flush_o,
  input logic               addr_err_o,
  input logic               sp_unpred_o
);
  logic              in_hit;
  logic [WORD_W-1:0] in_inc;
  logic [WORD_W-1:0] in_sum;
  logic              in_odd;
  logic              in_isa;
  logic [XLEN-1:0]   in_pc;

  always_comb begin
    in_hit = valid_i && (instr_i[15:10] == OPC_MAJOR) && (instr_i[4:0] == OPC_MINOR);
    in_inc = {{(WORD_W-IMM_W-IMM_SHIFT){1'b0}}, instr_i[9:5], 2'b00};
    in_sum = sp_i[WORD_W-1:0] + in_inc;
    in_odd = !((&sp_i[XLEN-1:WORD_W-1]) || (~|sp_i[XLEN-1:WORD_W-1]));
    in_isa = WIDE_ISA ? ra_i[0] : 1'b1;
    in_pc  = {ra_i[XLEN-1:1], 1'b0};
  end

  AST_HIT_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_hit |=> match_o); // R2
  AST_MISS_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_hit |=> !match_o); // R1
  AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (sp_we_o && flush_o && match_o)); // R9
  AST_QUIET_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !match_o |-> (!redirect_o && !sp_we_o && !flush_o && !addr_err_o && !sp_unpred_o)); // R11
  AST_PC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    in_hit |=> (pc_o == $past(in_pc))); // R6
  AST_STACK_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    in_hit |=> (sp_wdata_o[WORD_W-1:0] == $past(in_sum))); // R3
  AST_STACK_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we_o |-> (sp_wdata_o[XLEN-1:WORD_W] == {(XLEN-WORD_W){sp_wdata_o[WORD_W-1]}})); // R4
  AST_MODE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_hit |=> (isa_mode_o == $past(in_isa))); // R7
  AST_ERR_WITH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_o |-> redirect_o); // R8
  AST_UNPRED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_hit |=> (sp_unpred_o == $past(in_odd))); // R10
endmodule

bind cjump_stack_adj cjsa_checker #(.XLEN(XLEN), .WIDE_ISA(WIDE_ISA)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_i     (valid_i),
  .instr_i     (instr_i),
  .ra_i        (ra_i),
  .sp_i        (sp_i),
  .match_o     (match_o),
  .redirect_o  (redirect_o),
  .pc_o        (pc_o),
  .isa_mode_o  (isa_mode_o),
  .sp_we_o     (sp_we_o),
  .sp_wdata_o  (sp_wdata_o),
  .flush_o     (flush_o),
  .addr_err_o  (addr_err_o),
  .sp_unpred_o (sp_unpred_o)
);

// File: tb/cjump_stack_adj_tb_top.sv
module cjump_stack_adj_tb_top;
  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic [15:0] instr_i;
  logic [63:0] ra_i;
  logic [63:0] sp_i;

  logic        w_match, w_redir, w_isa, w_we, w_flush, w_err, w_unp;
  logic [63:0] w_pc, w_spw;
  logic        n_match, n_redir, n_isa, n_we, n_flush, n_err, n_unp;
  logic [63:0] n_pc, n_spw;

  int checks = 0;
  int fails  = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  cjump_stack_adj #(.XLEN(64), .WIDE_ISA(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .ra_i(ra_i), .sp_i(sp_i), .match_o(w_match), .redirect_o(w_redir),
    .pc_o(w_pc), .isa_mode_o(w_isa), .sp_we_o(w_we), .sp_wdata_o(w_spw),
    .flush_o(w_flush), .addr_err_o(w_err), .sp_unpred_o(w_unp));

  cjump_stack_adj #(.XLEN(64), .WIDE_ISA(1'b0)) dut_n_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .ra_i(ra_i), .sp_i(sp_i), .match_o(n_match), .redirect_o(n_redir),
    .pc_o(n_pc), .isa_mode_o(n_isa), .sp_we_o(n_we), .sp_wdata_o(n_spw),
    .flush_o(n_flush), .addr_err_o(n_err), .sp_unpred_o(n_unp));

  typedef struct packed {
    logic        m;
    logic [63:0] pc;
    logic        isa;
    logic [63:0] spw;
    logic        err;
    logic        unp;
  } res_t;

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] instr;
    logic        vld;
    logic [63:0] ra;
    logic [63:0] sp;
    res_t        exp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    // R3: immediate 0 leaves the low word unchanged
    '{4'd3, 16'h4413, 1'b1, 64'h0000_0000_0040_0001, 64'h0000_0000_1000_0000,
      '{1'b1, 64'h0000_0000_0040_0000, 1'b1, 64'h0000_0000_1000_0000, 1'b0, 1'b0}},
    // R3: immediate 31 adds 124; R6 clears bit 0 of a negative target
    '{4'd3, 16'h47F3, 1'b1, 64'hFFFF_FFFF_8000_1235, 64'h0000_0000_7FFF_0000,
      '{1'b1, 64'hFFFF_FFFF_8000_1234, 1'b1, 64'h0000_0000_7FFF_007C, 1'b0, 1'b0}},
    // R5: 32-bit wrap into the sign bit, then sign extension (R4)
    '{4'd5, 16'h4433, 1'b1, 64'h0000_0000_0000_1000, 64'h0000_0000_7FFF_FFFC,
      '{1'b1, 64'h0000_0000_0000_1000, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0}},
    // R7: 32-bit mode target with bit 1 set predicts an address error
    '{4'd7, 16'h4513, 1'b1, 64'h0000_0000_0000_2002, 64'hFFFF_FFFF_FFFF_FFE0,
      '{1'b1, 64'h0000_0000_0000_2002, 1'b0, 64'h0000_0000_0000_0000, 1'b1, 1'b0}},
    // R10: upper half not a sign extension; the sum is still produced
    '{4'd10, 16'h4513, 1'b1, 64'h0000_0000_0000_2003, 64'h0000_0001_0000_0000,
      '{1'b1, 64'h0000_0000_0000_2002, 1'b1, 64'h0000_0000_0000_0020, 1'b0, 1'b1}},
    // R11: wrong low field gives quiet outputs
    '{4'd11, 16'h4412, 1'b1, 64'h0000_0000_0000_3001, 64'h0000_0000_0000_1000,
      '{1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0}},
    // R1: wrong high field is no match
    '{4'd1, 16'h0413, 1'b1, 64'h0000_0000_0000_3001, 64'h0000_0000_0000_1000,
      '{1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0}},
    // R9: matching word without valid produces no strobes
    '{4'd9, 16'h4413, 1'b0, 64'h0000_0000_0000_3001, 64'h0000_0000_0000_1000,
      '{1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0}}
  };

  function automatic res_t wide_out();
    return '{w_match, w_pc, w_isa, w_spw, w_err, w_unp};
  endfunction

  function automatic res_t narrow_out();
    return '{n_match, n_pc, n_isa, n_spw, n_err, n_unp};
  endfunction

  task automatic compare(input string tag, input res_t act, input res_t exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual m=%b pc=%h isa=%b spw=%h err=%b unp=%b expected m=%b pc=%h isa=%b spw=%h err=%b unp=%b",
               tag, act.m, act.pc, act.isa, act.spw, act.err, act.unp,
               exp.m, exp.pc, exp.isa, exp.spw, exp.err, exp.unp);
    end
  endtask

  task automatic strobes(input string tag, input logic exp);
    checks++;
    if ({w_redir, w_we, w_flush} !== {3{exp}}) begin
      fails++;
      $display("FAIL %s: actual redirect/we/flush=%b%b%b expected all %b",
               tag, w_redir, w_we, w_flush, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] ins, input logic [63:0] ra, input logic [63:0] sp);
    valid_i = v;
    instr_i = ins;
    ra_i    = ra;
    sp_i    = sp;
  endtask

  localparam res_t QUIET = '{1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0};

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual run still active expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 16'h4413, 64'h1001, 64'h1000);
    repeat (3) @(negedge clk);
    // R12: a valid matching word during reset leaves everything quiet
    compare("R12 reset wide", wide_out(), QUIET);
    compare("R12 reset narrow", narrow_out(), QUIET);
    strobes("R12 reset strobes", 1'b0);
    rst_n = 1'b1;
    drive(1'b0, 16'h0, 64'h0, 64'h0);
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].vld, VECS[i].instr, VECS[i].ra, VECS[i].sp);
      @(negedge clk);
      compare($sformatf("R%0d vector %0d", VECS[i].req, i), wide_out(), VECS[i].exp);
      strobes($sformatf("R9 vector %0d", i), VECS[i].exp.m);
    end

    // R2: before the capturing edge the outputs still show the previous (idle) word
    drive(1'b1, 16'h4433, 64'h0000_0000_0000_5001, 64'h0000_0000_0000_0100);
    #1;
    compare("R2 before edge", wide_out(), QUIET);
    @(negedge clk);
    compare("R2 after edge", wide_out(),
            '{1'b1, 64'h5000, 1'b1, 64'h0000_0000_0000_0104, 1'b0, 1'b0});

    // R8: compressed-only core, even target -> error, mode stays compressed
    drive(1'b1, 16'h4413, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_0040);
    @(negedge clk);
    compare("R8 narrow even target", narrow_out(),
            '{1'b1, 64'h1000, 1'b1, 64'h40, 1'b1, 1'b0});
    compare("R7 wide same target", wide_out(),
            '{1'b1, 64'h1000, 1'b0, 64'h40, 1'b0, 1'b0});
    // R8: odd target -> no error
    drive(1'b1, 16'h4413, 64'h0000_0000_0000_1001, 64'h0000_0000_0000_0040);
    @(negedge clk);
    compare("R8 narrow odd target", narrow_out(),
            '{1'b1, 64'h1000, 1'b1, 64'h40, 1'b0, 1'b0});

    // R9: valid drops -> strobes drop on the next edge
    drive(1'b0, 16'h4413, 64'h1001, 64'h40);
    @(negedge clk);
    strobes("R9 valid dropped", 1'b0);
    compare("R11 idle after drop", wide_out(), QUIET);

    // R12: reset asserted mid-operation clears outputs at once
    drive(1'b1, 16'h4413, 64'h1001, 64'h40);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    compare("R12 async reset", wide_out(), QUIET);
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule